// File: doc/BRIEF.md
# Eight-channel interrupt controller

This block gathers eight interrupt request lines from peripherals into one interrupt request for a processor core. The core uses this request as its machine external interrupt, trap cause code 11 in the interrupt range. A rising edge on an enabled line is remembered as a pending request. The controller picks one pending channel, raises the core request and shows the channel number in its control word. That choice then stays fixed until software acknowledges it.

Software reaches the block through a single 32-bit control word with a write strobe and a read-back bus. In that word software sets a unit enable and one enable bit per channel. It reads the number of the channel being signalled and acknowledges the request it has serviced. It can also raise a request on any channel by writing a channel number together with a fire bit. The acknowledge bit, the channel number and the fire bit all clear themselves after the write.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `irq_to_core` is low and `reg_rdata` reads all zeros.
- R2: While the unit and channel i are enabled, a 0-to-1 change on `irq_in[i]` makes channel i pending. It stays pending after the line falls. A line that simply stays high raises no further request. The first edge at which the line is high records the request, and `irq_to_core` rises after the next clock edge.
- R3: Bits 15:8 hold the per-channel enables (bit 8+i for channel i) and read back as written. Edges on a channel whose enable is clear are lost, and clearing an enable drops that channel's pending request.
- R4: Bit 4 is the unit enable and reads back as written. Writing it to 0 forces `irq_to_core` low after that clock edge and discards every pending request. Edges that arrive while the unit is disabled are lost.
- R5: When more than one channel is pending, the lowest channel number is signalled first.
- R6: Bits 2:0 read the number of the signalled channel while `irq_to_core` is high and read 0 otherwise. Writes to these bits have no effect.
- R7: While `irq_to_core` is high, the signalled channel number does not change and the request stays high until it is acknowledged, even if new lines rise.
- R8: Writing 1 to bit 3 while a channel is signalled clears that channel's request. `irq_to_core` is then low for exactly one cycle before the next pending channel is signalled. Writing the bit while nothing is signalled has no effect. Bit 3 always reads 0.
- R9: A write with bit 19 set makes the channel numbered by bits 18:16 pending. This follows the enables as they stand after that same write. Bits 19:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current read-back of the control word |
| irq_in | input | 8 | Peripheral request lines, edge-sensitive |
| irq_to_core | output | 1 | Machine external interrupt request to the core |

## Verification
The embedded properties check on every cycle that:
- a captured edge becomes pending;
- a disabled channel holds nothing;
- the chosen source has no lower-numbered pending channel beside it;
- the source stays frozen until acknowledged;
- an acknowledge always drops the request for a cycle;
- a disabled unit never requests;
- the source field reads 0 while idle.

Only the bench scenarios can show the full orderings. These include draining a multi-channel burst in ascending order and the loss of an edge that arrived while a channel was disabled. They also cover the software trigger's effect through the register port and the discarding of pending work when the unit is turned off.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the interrupt controller.
// Bit positions of the control word are behavioural: software depends on them.
package irqc_pkg;
    localparam int IRQC_CHANNELS   = 8;
    localparam int IRQC_ID_W       = $clog2(IRQC_CHANNELS);
    localparam int IRQC_DATA_W     = 32;

    localparam int POS_SRC_LO      = 0;   // read-only source number
    localparam int POS_ACK         = 3;   // self-clearing acknowledge
    localparam int POS_UNIT_EN     = 4;   // global enable
    localparam int POS_CHEN_LO     = 8;   // per-channel enables
    localparam int POS_SWSEL_LO    = 16;  // software trigger channel
    localparam int POS_SWFIRE      = 19;  // software trigger fire

    // Stored configuration of the controller
    typedef struct packed {
        logic                     unit_en;
        logic [IRQC_CHANNELS-1:0] ch_en;
    } irqc_cfg_t;
endpackage

// File: rtl/irqc_regs.sv
// Module: control word decode and storage.
// Holds the unit and channel enables, turns a write into one-cycle
// acknowledge and software-trigger strobes, and assembles the read-back.
// Assumes a single control word, so no address decode is needed.
// The "effective" enables reflect a write landing on the current edge.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_CH = IRQC_CHANNELS,
    parameter int ID_W   = IRQC_ID_W,
    parameter int DATA_W = IRQC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              active,
    input  logic [ID_W-1:0]   src,
    output logic [DATA_W-1:0] rd_data,
    output logic              unit_en_now,
    output logic [NUM_CH-1:0] ch_en_now,
    output logic              ack_now,
    output logic [NUM_CH-1:0] sw_set
);

    irqc_cfg_t cfg_q;

    // Store enables on a write, clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.unit_en <= wr_data[POS_UNIT_EN];
            cfg_q.ch_en   <= wr_data[POS_CHEN_LO +: NUM_CH];
        end
    end

    // Enables as they will stand after this edge
    always_comb begin
        unit_en_now = wr_en ? wr_data[POS_UNIT_EN] : cfg_q.unit_en;
        ch_en_now   = wr_en ? wr_data[POS_CHEN_LO +: NUM_CH] : cfg_q.ch_en;
        ack_now     = wr_en & wr_data[POS_ACK];
    end

    // One-hot software trigger decoded from select and fire
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sw
        assign sw_set[i] = wr_en & wr_data[POS_SWFIRE]
                         & (wr_data[POS_SWSEL_LO +: ID_W] == ID_W'(i));
    end

    // Read-back: self-clearing fields always read zero
    always_comb begin
        rd_data                        = '0;
        rd_data[POS_SRC_LO +: ID_W]    = active ? src : '0;
        rd_data[POS_UNIT_EN]           = cfg_q.unit_en;
        rd_data[POS_CHEN_LO +: NUM_CH] = cfg_q.ch_en;
    end

    logic unused_wdata;
    assign unused_wdata = ^{wr_data[2:0], wr_data[7:5], wr_data[DATA_W-1:20]};

    // R6: the source field is zero whenever nothing is signalled
    p_src_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (rd_data[POS_SRC_LO +: ID_W] == '0));

    // R8, R9: self-clearing fields never read back as set
    p_selfclear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[POS_SWFIRE:POS_SWSEL_LO] == '0) && !rd_data[POS_ACK]);

endmodule

// File: rtl/irqc_capture.sv
// Module: per-channel edge detection and pending storage.
// Each channel remembers the previous level of its line. A rising edge,
// or a software strobe, marks it pending when both the unit and the
// channel are enabled. Assumes the lines are already synchronous to clk.
// On the same edge a new request wins over an acknowledge clear.
module irqc_capture #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lines,
    input  logic              unit_en_now,
    input  logic [NUM_CH-1:0] ch_en_now,
    input  logic [NUM_CH-1:0] sw_set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] pending
);

    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] pend_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic rise;
        assign rise = lines[i] & ~prev_q[i];

        // Track the line level regardless of enables
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lines[i];
        end

        // Set on edge or software strobe, drop on clear or disable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= unit_en_now & ch_en_now[i]
                           & ((pend_q[i] & ~clr[i]) | rise | sw_set[i]);
            end
        end

        // R2: an enabled rising edge always becomes pending
        p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_en_now && ch_en_now[i] && lines[i] && !prev_q[i]) |=> pend_q[i]);

        // R3: a disabled channel holds no request
        p_disabled_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en_now[i] |=> !pend_q[i]);
    end

    assign pending = pend_q;

endmodule

// File: rtl/irqc_arbiter.sv
// Module: source selection and request state.
// When idle it picks the lowest-numbered pending channel, raises the
// request and freezes the source number until an acknowledge arrives.
// An acknowledge returns it to idle for one cycle before the next pick.
// Assumes pending bits come from irqc_capture and are cleared via clr.
module irqc_arbiter #(
    parameter int NUM_CH = 8,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending,
    input  logic              unit_en_now,
    input  logic              ack_now,
    output logic              active,
    output logic [ID_W-1:0]   src,
    output logic [NUM_CH-1:0] clr
);

    logic            active_q;
    logic [ID_W-1:0] src_q;
    logic [ID_W-1:0] lowest;
    logic            any_pending;

    // Priority encoder: lowest index wins
    always_comb begin
        lowest      = '0;
        any_pending = |pending;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (pending[k]) lowest = ID_W'(k);
        end
    end

    // Request state: select, hold, release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            src_q    <= '0;
        end else if (!unit_en_now) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (ack_now) active_q <= 1'b0;
        end else if (any_pending) begin
            active_q <= 1'b1;
            src_q    <= lowest;
        end
    end

    // One-hot clear of the serviced channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
        assign clr[i] = active_q & ack_now & (src_q == ID_W'(i));
    end

    assign active = active_q;
    assign src    = src_q;

    function automatic logic [NUM_CH-1:0] below_mask(input logic [ID_W-1:0] s);
        logic [NUM_CH-1:0] m;
        for (int k = 0; k < NUM_CH; k++) m[k] = (ID_W'(k) < s);
        return m;
    endfunction

    // R5: no lower-numbered channel was pending when a source was chosen
    p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> (($past(pending) & below_mask(src_q)) == '0));

    // R7: the source stays frozen until acknowledged
    p_frozen_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !ack_now && unit_en_now) |=> (active_q && $stable(src_q)));

    // R8: an acknowledge always opens a one-cycle gap
    p_gap_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && ack_now) |=> !active_q);

endmodule

// File: rtl/irq_aggregator.sv
// Module: eight-channel interrupt controller top.
// Connects the control word, the edge capture and the arbiter, and
// drives the core's machine external interrupt from the arbiter state.
// Assumes a synchronous, active-low reset and synchronous request lines.
module irq_aggregator
    import irqc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [IRQC_DATA_W-1:0]   reg_wdata,
    output logic [IRQC_DATA_W-1:0]   reg_rdata,
    input  logic [IRQC_CHANNELS-1:0] irq_in,
    output logic                     irq_to_core
);

    localparam int NUM_CH = IRQC_CHANNELS;
    localparam int ID_W   = IRQC_ID_W;

    logic              unit_en_now;
    logic [NUM_CH-1:0] ch_en_now;
    logic              ack_now;
    logic [NUM_CH-1:0] sw_set;
    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] clr;
    logic              active;
    logic [ID_W-1:0]   src;

    irqc_regs #(.NUM_CH(NUM_CH), .ID_W(ID_W), .DATA_W(IRQC_DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .active      (active),
        .src         (src),
        .rd_data     (reg_rdata),
        .unit_en_now (unit_en_now),
        .ch_en_now   (ch_en_now),
        .ack_now     (ack_now),
        .sw_set      (sw_set)
    );

    irqc_capture #(.NUM_CH(NUM_CH)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines       (irq_in),
        .unit_en_now (unit_en_now),
        .ch_en_now   (ch_en_now),
        .sw_set      (sw_set),
        .clr         (clr),
        .pending     (pending)
    );

    irqc_arbiter #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending     (pending),
        .unit_en_now (unit_en_now),
        .ack_now     (ack_now),
        .active      (active),
        .src         (src),
        .clr         (clr)
    );

    assign irq_to_core = active;

    // R4: a disabled unit never requests the core
    p_disable_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en_now |=> !irq_to_core);

endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

    localparam logic [31:0] EN      = 32'h0000_0010;
    localparam logic [31:0] ALL     = 32'h0000_FF00;
    localparam logic [31:0] ACK     = 32'h0000_0008;
    localparam int          NVEC    = 6;
    localparam int          WD_CYC  = 20000;

    // Stimulus table: burst of rising lines and the first expected source
    localparam logic [7:0] VEC_MASK  [NVEC] = '{8'h01, 8'h80, 8'h81, 8'h3C, 8'hFF, 8'h52};
    localparam int         VEC_FIRST [NVEC] = '{0, 7, 0, 2, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_in = '0;
    logic        irq_to_core;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_aggregator uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_in      (irq_in),
        .irq_to_core (irq_to_core)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        step();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    function automatic logic [31:0] sw(input int ch);
        return 32'h0008_0000 | (32'(ch) << 16);
    endfunction

    task automatic pulse(input int ch);
        irq_in[ch] = 1'b1;
        step();
        irq_in[ch] = 1'b0;
    endtask

    initial begin
        #(WD_CYC * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        // R1 reset state
        chk("R1 irq", {31'b0, irq_to_core}, 32'd0);
        chk("R1 rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 rdata after release", reg_rdata, 32'd0);

        // Table walk: bursts drain in ascending order (R2, R5, R7, R8)
        wr(EN | ALL);
        for (int v = 0; v < NVEC; v++) begin
            irq_in = VEC_MASK[v];
            step(); step();
            chk("R2 burst irq", {31'b0, irq_to_core}, 32'd1);
            chk("R5 first source", {29'b0, reg_rdata[2:0]}, 32'(VEC_FIRST[v]));
            for (int k = 0; k < 8; k++) begin
                if (VEC_MASK[v][k]) begin
                    chk("R7 irq held", {31'b0, irq_to_core}, 32'd1);
                    chk("R5 order", {29'b0, reg_rdata[2:0]}, 32'(k));
                    wr(EN | ALL | ACK);
                    chk("R8 gap", {31'b0, irq_to_core}, 32'd0);
                    step();
                end
            end
            chk("R8 drained", {31'b0, irq_to_core}, 32'd0);
            chk("R6 idle source", {29'b0, reg_rdata[2:0]}, 32'd0);
            irq_in = '0;
            step();
        end

        // R3 enable readback and disabled channel
        wr(EN | 32'h0000_A500);
        chk("R3 readback", reg_rdata, EN | 32'h0000_A500);
        irq_in[1] = 1'b1;
        step(); step();
        chk("R3 disabled edge", {31'b0, irq_to_core}, 32'd0);
        wr(EN | ALL);
        step(); step();
        chk("R2 level no retrigger", {31'b0, irq_to_core}, 32'd0);
        irq_in = '0;
        step();

        // R6 source bits not writable
        wr(EN | ALL | 32'h7);
        chk("R6 write ignored", reg_rdata, EN | ALL);

        // R9 software trigger
        wr(EN | ALL | sw(5));
        chk("R9 fields read zero", reg_rdata, EN | ALL);
        step();
        chk("R9 irq", {31'b0, irq_to_core}, 32'd1);
        chk("R9 source", {29'b0, reg_rdata[2:0]}, 32'd5);
        wr(EN | ALL | ACK);
        chk("R8 ack reads zero", reg_rdata, EN | ALL);
        step();
        wr(EN | 32'h0000_FE00 | sw(0));
        step(); step();
        chk("R9 disabled channel", {31'b0, irq_to_core}, 32'd0);
        wr(EN | ALL);

        // R7 freeze while a higher-priority line rises
        pulse(3);
        step();
        chk("R7 src3", {29'b0, reg_rdata[2:0]}, 32'd3);
        pulse(1);
        step();
        chk("R7 still high", {31'b0, irq_to_core}, 32'd1);
        chk("R7 frozen", {29'b0, reg_rdata[2:0]}, 32'd3);
        wr(EN | ALL | ACK);
        chk("R8 one-cycle low", {31'b0, irq_to_core}, 32'd0);
        step();
        chk("R8 next source", {29'b0, reg_rdata[2:0]}, 32'd1);
        wr(EN | ALL | ACK);
        step();

        // R8 acknowledge while idle has no effect
        wr(EN | ALL | ACK);
        chk("R8 idle ack", {31'b0, irq_to_core}, 32'd0);
        pulse(2);
        step();
        chk("R8 after idle ack", {29'b0, reg_rdata[2:0]}, 32'd2);
        wr(EN | ALL | ACK);
        step();

        // R4 disable discards pending work
        irq_in = 8'h50;
        step(); step();
        irq_in = '0;
        chk("R4 active src4", {29'b0, reg_rdata[2:0]}, 32'd4);
        wr(ALL);
        chk("R4 irq drops", {31'b0, irq_to_core}, 32'd0);
        chk("R4 readback", reg_rdata, ALL);
        wr(EN | ALL);
        step(); step();
        chk("R4 pending discarded", {31'b0, irq_to_core}, 32'd0);
        wr(ALL);
        pulse(0);
        wr(EN | ALL);
        step(); step();
        chk("R4 edge while off lost", {31'b0, irq_to_core}, 32'd0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule